// File: doc/BRIEF.md
# Load hit/miss speculation controller

This block decides, for each integer load, whether the instructions that consume its result may be woken before the data cache has reported a hit. When a load is issued, a table of saturating counters indexed by the load's PC predicts hit or miss. On a predicted hit, the load's destination tag is broadcast as a speculative wakeup in the next cycle. This lets consumers issue early enough to meet the nominal 3-cycle load-to-use latency. On a predicted miss, nothing is broadcast until the cache outcome is known.

The cache reports the outcome on `resp_hit` at a fixed point after issue. Four cases follow:
- A predicted miss that actually hits is woken then, two cycles later than a speculative wakeup. This gives an effective latency of 5 cycles.
- A predicted hit that actually misses raises `squash` for two cycles. This tells the issue logic to pull the instructions it issued in those two integer issue cycles back into the issue queue for re-issue.
- The counter of the load is trained on every outcome.
- Loads may issue every cycle, and each one is tracked to its outcome independently.

Top module: `lhm_spec_ctrl`

## Requirements
- R1: After reset all outputs are low and every counter holds 2, so the first load of any PC is predicted to hit.
- R2: A load issued with `ld_vld` in cycle t whose counter reads 2 or 3 drives `spec_wake_vld` high with `spec_wake_tag` equal to its `ld_tag` in cycle t+1, for that one cycle.
- R3: A load whose counter reads 0 or 1 produces no `spec_wake_vld`.
- R4: The outcome of a load issued in cycle t is taken from `resp_hit` in cycle t+HIT_LAT-1. If that load was predicted to miss and `resp_hit` is 1, then `late_wake_vld` is high with its tag in cycle t+HIT_LAT for one cycle. This is two cycles after a speculative wakeup would have come, making the load-to-use latency 5.
- R5: If a load was predicted to hit and `resp_hit` is 0 in its outcome cycle, `squash` is high for exactly SQUASH_CYC (2) cycles, from cycle t+HIT_LAT.
- R6: Correct predictions (hit/hit and miss/miss) raise neither `late_wake_vld` nor `squash`. A `resp_hit` with no load at its outcome cycle has no effect on any output and trains no counter.
- R7: Each counter is 2 bits wide. It rises by one on a hit and falls by one on a miss, saturating at 3 and at 0.
- R8: The counter index is the XOR of all IDX_W-bit slices of `ld_pc`, with the lowest slice starting at bit 0. PCs whose slices fold to the same value share one counter.
- R9: Loads may issue on consecutive cycles and each is tracked independently. Squash windows that overlap merge into one pulse that ends SQUASH_CYC cycles after the last mispredicted outcome.
- R10: A counter update made in a load's outcome cycle is seen by a load issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_vld | input | 1 | An integer load issues this cycle |
| ld_pc | input | PC_W | PC of the issuing load |
| ld_tag | input | TAG_W | Destination tag of the issuing load |
| resp_hit | input | 1 | Cache outcome of the load issued HIT_LAT-1 cycles ago: 1 hit, 0 miss |
| spec_wake_vld | output | 1 | Speculative wakeup of a predicted-hit load |
| spec_wake_tag | output | TAG_W | Tag for the speculative wakeup |
| late_wake_vld | output | 1 | Wakeup of a predicted-miss load that hit |
| late_wake_tag | output | TAG_W | Tag for the late wakeup |
| squash | output | 1 | Squash-and-replay window after a mispredicted hit |

## Verification
The bench builds the block with its default parameters: a 16-bit PC folded into a 4-bit index, a hit latency of 3 and a 2-cycle squash. With 16 counters, PCs that alias onto one counter are easy to pick, and every counter can be walked through both saturation points within a few loads. The 3-cycle latency places the outcome two cycles after issue. That makes the 5-cycle late wakeup observable. It also lets two back-to-back mispredicted loads stretch the squash to three cycles, while a third load reads the counter just trained.

// File: rtl/lhm_pkg.sv
`timescale 1ns/1ps
package lhm_pkg;

  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_TOP = '1;
  localparam ctr_t CTR_BOT = '0;

  // one training step of a saturating confidence counter
  function automatic ctr_t ctr_step(ctr_t cur, logic was_hit);
    ctr_t nxt;
    if (was_hit) nxt = (cur == CTR_TOP) ? cur : ctr_t'(cur + ctr_t'(1));
    else         nxt = (cur == CTR_BOT) ? cur : ctr_t'(cur - ctr_t'(1));
    return nxt;
  endfunction

  // upper half of the counter range means "expect a hit"
  function automatic logic ctr_predicts_hit(ctr_t cur);
    return cur[CTR_W-1];
  endfunction

endpackage

// File: rtl/lhm_predictor.sv
`timescale 1ns/1ps
module lhm_predictor
  import lhm_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int CTR_INIT = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_hit,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_hit
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TBL_W   = ENTRIES * CTR_W;

  logic [TBL_W-1:0] tbl_flat;
  ctr_t             rd_ctr;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    ctr_t ctr_q;
    ctr_t ctr_d;
    logic ctr_en;

    always_comb begin
      ctr_en = upd_en && (upd_idx == IDX_W'(e));
      ctr_d  = ctr_step(ctr_q, upd_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctr_q <= ctr_t'(CTR_INIT);
      else if (ctr_en) ctr_q <= ctr_d;
    end

    assign tbl_flat[e*CTR_W +: CTR_W] = ctr_q;
  end

  always_comb begin
    rd_ctr = tbl_flat[int'(rd_idx)*CTR_W +: CTR_W];
    rd_hit = ctr_predicts_hit(rd_ctr);
  end

endmodule

// File: rtl/lhm_track_pipe.sv
`timescale 1ns/1ps
module lhm_track_pipe #(
  parameter int DEPTH = 2,
  parameter int W     = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         tail_vld,
  output logic [W-1:0] tail_data
);

  logic [DEPTH-1:0]        vld_q, vld_d;
  logic [DEPTH-1:0][W-1:0] dat_q, dat_d;

  always_comb begin
    vld_d    = {vld_q[DEPTH-2:0], in_vld};
    dat_d[0] = in_data;
    for (int s = 1; s < DEPTH; s++) dat_d[s] = dat_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      for (int s = 0; s < DEPTH; s++) begin
        if (vld_d[s]) dat_q[s] <= dat_d[s];
      end
    end
  end

  assign tail_vld  = vld_q[DEPTH-1];
  assign tail_data = dat_q[DEPTH-1];

endmodule

// File: rtl/lhm_squash_gen.sv
`timescale 1ns/1ps
module lhm_squash_gen #(
  parameter int PULSE_CYC = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic squash
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (trig)              cnt_d = CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign squash = (cnt_q != '0);

endmodule

// File: rtl/lhm_spec_ctrl.sv
`timescale 1ns/1ps
module lhm_spec_ctrl
  import lhm_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int TAG_W      = 6,
  parameter int IDX_W      = 4,
  parameter int HIT_LAT    = 3,
  parameter int SQUASH_CYC = 2,
  parameter int CTR_INIT   = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_vld,
  input  logic [PC_W-1:0]  ld_pc,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic             resp_hit,
  output logic             spec_wake_vld,
  output logic [TAG_W-1:0] spec_wake_tag,
  output logic             late_wake_vld,
  output logic [TAG_W-1:0] late_wake_tag,
  output logic             squash
);

  localparam int TRK_DEPTH = HIT_LAT - 1;
  localparam int N_SLICE   = (PC_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W     = N_SLICE * IDX_W;
  localparam int TRK_W     = IDX_W + TAG_W + 1;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             pred_hit;
  } trk_t;

  // index hashing: fold the PC into IDX_W bits
  logic [PAD_W-1:0] pc_pad;
  logic [IDX_W-1:0] ld_idx;

  always_comb begin
    pc_pad = PAD_W'(ld_pc);
    ld_idx = '0;
    for (int c = 0; c < N_SLICE; c++) ld_idx = ld_idx ^ pc_pad[c*IDX_W +: IDX_W];
  end

  // predictor lookup and training
  logic pred_now;
  logic tail_vld;
  logic [TRK_W-1:0] tail_data;
  trk_t in_rec, tail_rec;

  assign tail_rec = trk_t'(tail_data);

  lhm_predictor #(
    .IDX_W    (IDX_W),
    .CTR_INIT (CTR_INIT)
  ) u_pred (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (ld_idx),
    .rd_hit  (pred_now),
    .upd_en  (tail_vld),
    .upd_idx (tail_rec.idx),
    .upd_hit (resp_hit)
  );

  // outcome tracking
  always_comb begin
    in_rec.idx      = ld_idx;
    in_rec.tag      = ld_tag;
    in_rec.pred_hit = pred_now;
  end

  lhm_track_pipe #(
    .DEPTH (TRK_DEPTH),
    .W     (TRK_W)
  ) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (ld_vld),
    .in_data   (in_rec),
    .tail_vld  (tail_vld),
    .tail_data (tail_data)
  );

  // wakeup next-state
  logic             spec_vld_d, spec_vld_q;
  logic [TAG_W-1:0] spec_tag_q;
  logic             late_vld_d, late_vld_q;
  logic [TAG_W-1:0] late_tag_q;
  logic             mispredict_hit;

  always_comb begin
    spec_vld_d     = ld_vld && pred_now;
    late_vld_d     = tail_vld && !tail_rec.pred_hit && resp_hit;
    mispredict_hit = tail_vld && tail_rec.pred_hit && !resp_hit;
  end

  // wakeup registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spec_vld_q <= 1'b0;
      spec_tag_q <= '0;
      late_vld_q <= 1'b0;
      late_tag_q <= '0;
    end else begin
      spec_vld_q <= spec_vld_d;
      late_vld_q <= late_vld_d;
      if (spec_vld_d) spec_tag_q <= ld_tag;
      if (late_vld_d) late_tag_q <= tail_rec.tag;
    end
  end

  lhm_squash_gen #(
    .PULSE_CYC (SQUASH_CYC)
  ) u_sq (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (mispredict_hit),
    .squash (squash)
  );

  assign spec_wake_vld = spec_vld_q;
  assign spec_wake_tag = spec_tag_q;
  assign late_wake_vld = late_vld_q;
  assign late_wake_tag = late_tag_q;

endmodule

// File: rtl/lhm_spec_ctrl_chk.sv
`timescale 1ns/1ps
module lhm_spec_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_vld,
  input logic resp_hit,
  input logic spec_wake_vld,
  input logic late_wake_vld,
  input logic squash
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!spec_wake_vld && !late_wake_vld && !squash)
        else $error("outputs active during reset");
    end
  end

  assert_spec_after_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spec_wake_vld |-> $past(ld_vld));

  assert_late_after_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    late_wake_vld |-> $past(resp_hit));

  assert_squash_min_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(squash) |=> squash);

  assert_squash_after_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(squash) |-> !$past(resp_hit));

endmodule

bind lhm_spec_ctrl lhm_spec_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ld_vld        (ld_vld),
  .resp_hit      (resp_hit),
  .spec_wake_vld (spec_wake_vld),
  .late_wake_vld (late_wake_vld),
  .squash        (squash)
);

// File: tb/test_lhm_spec_ctrl.sv
`timescale 1ns/1ps
module test_lhm_spec_ctrl;

  logic       clk;
  logic       rst_n;
  logic       ld_vld;
  logic [15:0] ld_pc;
  logic [5:0] ld_tag;
  logic       resp_hit;
  logic       spec_wake_vld;
  logic [5:0] spec_wake_tag;
  logic       late_wake_vld;
  logic [5:0] late_wake_tag;
  logic       squash;

  int n_chk;
  int n_err;
  int model_ctr [16];

  lhm_spec_ctrl i_lhm_spec_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_vld        (ld_vld),
    .ld_pc         (ld_pc),
    .ld_tag        (ld_tag),
    .resp_hit      (resp_hit),
    .spec_wake_vld (spec_wake_vld),
    .spec_wake_tag (spec_wake_tag),
    .late_wake_vld (late_wake_vld),
    .late_wake_tag (late_wake_tag),
    .squash        (squash)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int fold_idx(logic [15:0] pc);
    return int'(pc[3:0] ^ pc[7:4] ^ pc[11:8] ^ pc[15:12]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_train(int idx, bit hit);
    if (hit) model_ctr[idx] = (model_ctr[idx] == 3) ? 3 : model_ctr[idx] + 1;
    else     model_ctr[idx] = (model_ctr[idx] == 0) ? 0 : model_ctr[idx] - 1;
  endfunction

  // one isolated load, checked cycle by cycle
  task automatic run_load(logic [15:0] pc, logic [5:0] tag, bit hit, string req);
    int idx;
    bit pred;
    idx  = fold_idx(pc);
    pred = (model_ctr[idx] >= 2);
    @(negedge clk);
    ld_vld = 1'b1; ld_pc = pc; ld_tag = tag;
    @(negedge clk);
    ld_vld = 1'b0;
    chk(req, "spec_wake_vld t+1", int'(spec_wake_vld), int'(pred));
    if (pred) chk(req, "spec_wake_tag t+1", int'(spec_wake_tag), int'(tag));
    chk(req, "late_wake_vld t+1", int'(late_wake_vld), 0);
    chk(req, "squash t+1", int'(squash), 0);
    @(negedge clk);
    resp_hit = hit;
    chk(req, "spec_wake_vld t+2", int'(spec_wake_vld), 0);
    @(negedge clk);
    resp_hit = 1'b0;
    chk(req, "late_wake_vld t+3", int'(late_wake_vld), int'(!pred && hit));
    if (!pred && hit) chk(req, "late_wake_tag t+3", int'(late_wake_tag), int'(tag));
    chk(req, "squash t+3", int'(squash), int'(pred && !hit));
    model_train(idx, hit);
    @(negedge clk);
    chk(req, "squash t+4", int'(squash), int'(pred && !hit));
    chk(req, "late_wake_vld t+4", int'(late_wake_vld), 0);
    @(negedge clk);
    chk(req, "squash t+5", int'(squash), 0);
  endtask

  task automatic t_reset;
    chk("R1", "spec_wake_vld after reset", int'(spec_wake_vld), 0);
    chk("R1", "late_wake_vld after reset", int'(late_wake_vld), 0);
    chk("R1", "squash after reset", int'(squash), 0);
    run_load(16'h0007, 6'd7, 1'b1, "R1");
  endtask

  task automatic t_hit_path;
    run_load(16'h0100, 6'd11, 1'b1, "R2");
    run_load(16'h0100, 6'd12, 1'b1, "R2");
  endtask

  task automatic t_mispredicted_hit;
    run_load(16'h0200, 6'd21, 1'b0, "R5");
    run_load(16'h0200, 6'd22, 1'b1, "R4");
    run_load(16'h0200, 6'd23, 1'b1, "R3");
  endtask

  task automatic t_alias;
    // 0x0010, 0x1000 and 0x0001 fold onto the same counter as 0x0100
    run_load(16'h0010, 6'd31, 1'b0, "R8");
    run_load(16'h1000, 6'd32, 1'b0, "R8");
    run_load(16'h0001, 6'd33, 1'b1, "R8");
  endtask

  task automatic t_saturate;
    run_load(16'h0300, 6'd41, 1'b0, "R7");
    run_load(16'h0300, 6'd42, 1'b0, "R7");
    run_load(16'h0300, 6'd43, 1'b0, "R7");
    run_load(16'h0300, 6'd44, 1'b1, "R7");
    run_load(16'h0300, 6'd45, 1'b1, "R7");
    run_load(16'h0300, 6'd46, 1'b1, "R7");
    run_load(16'h0300, 6'd47, 1'b1, "R7");
    run_load(16'h0300, 6'd48, 1'b0, "R7");
    run_load(16'h0300, 6'd49, 1'b1, "R7");
  endtask

  task automatic t_correct_miss_and_stray;
    run_load(16'h0004, 6'd51, 1'b0, "R6");
    run_load(16'h0004, 6'd52, 1'b0, "R6");
    // stray hit responses with nothing due
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      resp_hit = 1'b1;
    end
    @(negedge clk);
    resp_hit = 1'b0;
    chk("R6", "late_wake_vld after stray", int'(late_wake_vld), 0);
    chk("R6", "squash after stray", int'(squash), 0);
    @(negedge clk);
    chk("R6", "late_wake_vld after stray +1", int'(late_wake_vld), 0);
    // counter must still predict miss
    run_load(16'h0004, 6'd53, 1'b0, "R6");
  endtask

  task automatic t_back_to_back;
    int ia;
    int ib;
    ia = fold_idx(16'h0005);
    ib = fold_idx(16'h0006);
    @(negedge clk);                             // c0: load A
    ld_vld = 1'b1; ld_pc = 16'h0005; ld_tag = 6'd61;
    @(negedge clk);                             // c1: load B
    ld_pc = 16'h0006; ld_tag = 6'd62;
    chk("R9", "spec wake A", int'(spec_wake_vld), 1);
    chk("R9", "spec tag A", int'(spec_wake_tag), 61);
    @(negedge clk);                             // c2: A misses
    ld_vld = 1'b0; resp_hit = 1'b0;
    chk("R9", "spec wake B", int'(spec_wake_vld), 1);
    chk("R9", "spec tag B", int'(spec_wake_tag), 62);
    model_train(ia, 1'b0);
    @(negedge clk);                             // c3: B misses, load C on A's PC
    ld_vld = 1'b1; ld_pc = 16'h0005; ld_tag = 6'd63;
    chk("R9", "squash c3", int'(squash), 1);
    chk("R9", "late wake c3", int'(late_wake_vld), 0);
    model_train(ib, 1'b0);
    @(negedge clk);                             // c4
    ld_vld = 1'b0;
    chk("R9", "squash c4", int'(squash), 1);
    chk("R10", "C sees trained counter, no spec wake", int'(spec_wake_vld), 0);
    @(negedge clk);                             // c5: C hits
    resp_hit = 1'b1;
    chk("R9", "squash c5 extended", int'(squash), 1);
    model_train(ia, 1'b1);
    @(negedge clk);                             // c6
    resp_hit = 1'b0;
    chk("R9", "squash c6 ended", int'(squash), 0);
    chk("R10", "late wake C", int'(late_wake_vld), 1);
    chk("R10", "late tag C", int'(late_wake_tag), 63);
    @(negedge clk);
    chk("R10", "late wake one cycle", int'(late_wake_vld), 0);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    for (int i = 0; i < 16; i++) model_ctr[i] = 2;
    rst_n    = 1'b0;
    ld_vld   = 1'b0;
    ld_pc    = '0;
    ld_tag   = '0;
    resp_hit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_hit_path;
    t_mispredicted_hit;
    t_alias;
    t_saturate;
    t_correct_miss_and_stray;
    t_back_to_back;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule